// File: doc/BRIEF.md
# Two-Bank Memory-Mapped GPIO with Change Interrupt

This block gives a processor control of up to two banks of general-purpose pins, each up to 32 pins wide, through a plain 32-bit register bus. Each bank has an output-value latch and a direction latch. A direction bit of one releases the pin so it acts as an input. A direction bit of zero drives the pin from the latch. Software reads a bank's data address to see the pin levels. Input pins return their synchronised external level. Output pins return the latched value.

Every input pin goes through a two-flop synchroniser. Each bank then has one change detector that compares the newest synchronised sample with the one before it. Any change on any input pin of a bank, rising or falling, sets that bank's single sticky status bit. Software clears a status bit by writing a one to it. A per-bank enable mask and one global enable bit decide whether pending status drives the interrupt output. The second bank exists only when the dual-bank parameter is set.

Top module: `pio_dual`

## Requirements
- R1: The register map uses byte addresses, and read data appears on `bus_rdata` the cycle after the address is presented. Bank A data is at 0x000 and bank A direction at 0x004. Bank B data is at 0x008 and bank B direction at 0x00C. The global enable is at 0x11C and is held in bit 31 only. Interrupt status is at 0x120 and interrupt enable at 0x128. In both of those, bit 0 is bank A and bit 1 is bank B. Any other address reads zero.
- R2: A direction bit of 1 makes the pin an input, with its `pin_oe` bit low. A direction bit of 0 sets its `pin_oe` bit high, and `pin_out` then carries the data latch bit. Both take effect on the clock edge after the write.
- R3: After reset, every direction bit is 1 and every data latch bit is 0 (both values are parameters). Status, enable and global enable are 0, and `irq` is low.
- R4: A data read returns the synchronised pin level for input pins and the latched value for output pins. Bits above the bank width read 0.
- R5: A status bit sets within four clocks after any input pin of its bank changes level, in either direction. Level changes on pins configured as outputs never set it.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a change event and a clear land on the same edge, the event wins.
- R7: `irq` is a register that goes high one clock after the global enable is set and (status AND enable) is non-zero. Otherwise it goes low.
- R8: With the dual-bank parameter clear, the bank B registers read 0, writes to them are ignored, and status bit 1 never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in_a | input | WIDTH_A | External levels of bank A pins |
| pin_out_a | output | WIDTH_A | Drive values of bank A pins |
| pin_oe_a | output | WIDTH_A | Output enables of bank A pins, high = driven |
| pin_in_b | input | WIDTH_B | External levels of bank B pins |
| pin_out_b | output | WIDTH_B | Drive values of bank B pins |
| pin_oe_b | output | WIDTH_B | Output enables of bank B pins, high = driven |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded assertions check four things on every clock edge. A direction write shows up as the inverted output enable on the next edge. Direction and data latches hold their parameter values right after reset. A status bit stays set until a one is written to it, and it drops after that write unless an event arrives in the same cycle. With the global enable off, the interrupt stays low. The bench scenarios cover the rest: the full address decode and the zeroed unused and unmapped bits, the merged read of pin levels with latch values, that output-pin toggles are ignored, detection of both edge directions through the synchroniser, and the single-bank build.

// File: rtl/pio_dual_pkg.sv
package pio_dual_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 9;
  localparam int NBANK  = 2;

  localparam logic [ADDR_W-1:0] OFF_A_DATA = 9'h000;
  localparam logic [ADDR_W-1:0] OFF_A_DIR  = 9'h004;
  localparam logic [ADDR_W-1:0] OFF_B_DATA = 9'h008;
  localparam logic [ADDR_W-1:0] OFF_B_DIR  = 9'h00C;
  localparam logic [ADDR_W-1:0] OFF_GEN    = 9'h11C;
  localparam logic [ADDR_W-1:0] OFF_STS    = 9'h120;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 9'h128;

  localparam int GEN_BIT = 31;
endpackage

// File: rtl/pio_dual_chan.sv
module pio_dual_chan #(
  parameter int           W        = 32,
  parameter logic [W-1:0] DATA_RST = '0,
  parameter logic [W-1:0] DIR_RST  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic         change
);
  logic [W-1:0] data_q, dir_q;
  logic [W-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= DATA_RST;
      dir_q  <= DIR_RST;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = ~dir_q;
  assign rd_dir  = dir_q;
  assign rd_data = (data_q & ~dir_q) | (sync2_q & dir_q);
  assign change  = |((sync2_q ^ prev_q) & dir_q);

  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> pin_oe == ~$past(wdata));

  assert_reset_latches_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == ~DIR_RST) && (pin_out == DATA_RST));
endmodule

// File: rtl/pio_dual_irq.sv
module pio_dual_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sts,
  input  logic         wr_ien,
  input  logic         wr_gen,
  input  logic [N-1:0] wbits,
  input  logic         wgen,
  input  logic [N-1:0] event_in,
  output logic [N-1:0] sts,
  output logic [N-1:0] ien,
  output logic         gen,
  output logic         irq
);
  logic [N-1:0] clr;

  assign clr = wr_sts ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      ien <= '0;
      gen <= 1'b0;
      irq <= 1'b0;
    end else begin
      sts <= (sts & ~clr) | event_in;
      if (wr_ien) ien <= wbits;
      if (wr_gen) gen <= wgen;
      irq <= gen & |(sts & ien);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      sts[i] && !(wr_sts && wbits[i]) |=> sts[i]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
      wr_sts && wbits[i] && !event_in[i] |=> !sts[i]);
  end

  assert_gen_gates_R7: assert property (@(posedge clk) disable iff (rst)
    !gen |=> !irq);
endmodule

// File: rtl/pio_dual.sv
module pio_dual
  import pio_dual_pkg::*;
#(
  parameter int               WIDTH_A    = 32,
  parameter int               WIDTH_B    = 32,
  parameter bit               DUAL       = 1'b1,
  parameter logic [WIDTH_A-1:0] A_DATA_RST = '0,
  parameter logic [WIDTH_A-1:0] A_DIR_RST  = '1,
  parameter logic [WIDTH_B-1:0] B_DATA_RST = '0,
  parameter logic [WIDTH_B-1:0] B_DIR_RST  = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [WIDTH_A-1:0] pin_in_a,
  output logic [WIDTH_A-1:0] pin_out_a,
  output logic [WIDTH_A-1:0] pin_oe_a,
  input  logic [WIDTH_B-1:0] pin_in_b,
  output logic [WIDTH_B-1:0] pin_out_b,
  output logic [WIDTH_B-1:0] pin_oe_b,
  output logic               irq
);
  logic [WIDTH_A-1:0] a_rd, a_dir;
  logic [WIDTH_B-1:0] b_rd, b_dir;
  logic               a_chg, b_chg;
  logic [NBANK-1:0]   sts, ien, evt;
  logic               gen;

  pio_dual_chan #(.W(WIDTH_A), .DATA_RST(A_DATA_RST), .DIR_RST(A_DIR_RST)) u_bank_a (
    .clk(clk), .rst(rst),
    .wr_data(bus_we && bus_addr == OFF_A_DATA),
    .wr_dir (bus_we && bus_addr == OFF_A_DIR),
    .wdata(bus_wdata[WIDTH_A-1:0]), .pin_in(pin_in_a),
    .pin_out(pin_out_a), .pin_oe(pin_oe_a),
    .rd_data(a_rd), .rd_dir(a_dir), .change(a_chg)
  );

  if (DUAL) begin : g_bank_b
    pio_dual_chan #(.W(WIDTH_B), .DATA_RST(B_DATA_RST), .DIR_RST(B_DIR_RST)) u_bank_b (
      .clk(clk), .rst(rst),
      .wr_data(bus_we && bus_addr == OFF_B_DATA),
      .wr_dir (bus_we && bus_addr == OFF_B_DIR),
      .wdata(bus_wdata[WIDTH_B-1:0]), .pin_in(pin_in_b),
      .pin_out(pin_out_b), .pin_oe(pin_oe_b),
      .rd_data(b_rd), .rd_dir(b_dir), .change(b_chg)
    );
  end else begin : g_no_bank_b
    assign pin_out_b = '0;
    assign pin_oe_b  = '0;
    assign b_rd      = '0;
    assign b_dir     = '0;
    assign b_chg     = 1'b0;
  end

  assign evt = {b_chg, a_chg};

  pio_dual_irq #(.N(NBANK)) u_irq (
    .clk(clk), .rst(rst),
    .wr_sts(bus_we && bus_addr == OFF_STS),
    .wr_ien(bus_we && bus_addr == OFF_IEN),
    .wr_gen(bus_we && bus_addr == OFF_GEN),
    .wbits(bus_wdata[NBANK-1:0]), .wgen(bus_wdata[GEN_BIT]),
    .event_in(evt), .sts(sts), .ien(ien), .gen(gen), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        OFF_A_DATA: bus_rdata <= BUS_W'(a_rd);
        OFF_A_DIR:  bus_rdata <= BUS_W'(a_dir);
        OFF_B_DATA: bus_rdata <= BUS_W'(b_rd);
        OFF_B_DIR:  bus_rdata <= BUS_W'(b_dir);
        OFF_GEN:    bus_rdata <= {gen, {(BUS_W-1){1'b0}}};
        OFF_STS:    bus_rdata <= BUS_W'(sts);
        OFF_IEN:    bus_rdata <= BUS_W'(ien);
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/pio_dual_tb.sv
module pio_dual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  addr = '0;
  logic        we_m = 1'b0, we_s = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_m, rdata_s;
  logic [31:0] pin_in_a = '0, pin_in_b = '0;
  logic [31:0] pin_out_a, pin_oe_a, pin_out_b, pin_oe_b;
  logic        irq_m;
  logic [7:0]  s_in_a = '0, s_out_a, s_oe_a;
  logic [31:0] s_in_b = '0, s_out_b, s_oe_b;
  logic        irq_s;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_dual u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we_m), .bus_wdata(wdata),
    .bus_rdata(rdata_m), .pin_in_a(pin_in_a), .pin_out_a(pin_out_a), .pin_oe_a(pin_oe_a),
    .pin_in_b(pin_in_b), .pin_out_b(pin_out_b), .pin_oe_b(pin_oe_b), .irq(irq_m)
  );

  pio_dual #(.WIDTH_A(8), .DUAL(1'b0)) u_dut_single (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we_s), .bus_wdata(wdata),
    .bus_rdata(rdata_s), .pin_in_a(s_in_a), .pin_out_a(s_out_a), .pin_oe_a(s_oe_a),
    .pin_in_b(s_in_b), .pin_out_b(s_out_b), .pin_oe_b(s_oe_b), .irq(irq_s)
  );

  // vector: {write, address, write data, expected read}
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 9'h004, 32'h0,         32'hFFFF_FFFF},
    {1'b0, 9'h00C, 32'h0,         32'hFFFF_FFFF},
    {1'b0, 9'h000, 32'h0,         32'h0000_0000},
    {1'b1, 9'h000, 32'hA5A5_0F0F, 32'h0},
    {1'b1, 9'h004, 32'h0000_0000, 32'h0},
    {1'b0, 9'h000, 32'h0,         32'hA5A5_0F0F},
    {1'b1, 9'h008, 32'h1234_5678, 32'h0},
    {1'b1, 9'h00C, 32'h0000_FFFF, 32'h0},
    {1'b0, 9'h008, 32'h0,         32'h1234_0000},
    {1'b0, 9'h00C, 32'h0,         32'h0000_FFFF},
    {1'b1, 9'h11C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 9'h11C, 32'h0,         32'h8000_0000},
    {1'b1, 9'h128, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 9'h128, 32'h0,         32'h0000_0003},
    {1'b1, 9'h11C, 32'h0,         32'h0},
    {1'b1, 9'h128, 32'h0,         32'h0},
    {1'b0, 9'h124, 32'h0,         32'h0},
    {1'b0, 9'h010, 32'h0,         32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit single, input logic [8:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (single) we_s = 1'b1; else we_m = 1'b1;
    @(negedge clk);
    we_s = 1'b0; we_m = 1'b0;
  endtask

  task automatic rd(input bit single, input logic [8:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = single ? rdata_s : rdata_m;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    check("R3 oe_a", pin_oe_a, 32'h0);
    check("R3 out_a", pin_out_a, 32'h0);
    check("R3 oe_b", pin_oe_b, 32'h0);
    check("R3 irq", {31'h0, irq_m}, 32'h0);
    rd(0, 9'h120, v); check("R3 status", v, 32'h0);

    // R1 register map walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][73]) wr(0, VEC[i][72:64], VEC[i][63:32]);
      else begin
        rd(0, VEC[i][72:64], v);
        check("R1 map", v, VEC[i][31:0]);
      end
    end

    // R2 direction and drive
    check("R2 out_a", pin_out_a, 32'hA5A5_0F0F);
    check("R2 oe all", pin_oe_a, 32'hFFFF_FFFF);
    wr(0, 9'h004, 32'hFFFF_0000);
    check("R2 oe split", pin_oe_a, 32'h0000_FFFF);

    // R4 merged read
    wr(0, 9'h000, 32'h0000_1234);
    pin_in_a = 32'hBEEF_FFFF;
    idle(6);
    rd(0, 9'h000, v); check("R4 merged", v, 32'hBEEF_1234);

    // R5 change detection
    wr(0, 9'h120, 32'h3);
    rd(0, 9'h120, v); check("R5 cleared", v, 32'h0);
    pin_in_a = 32'hBEEF_0000;
    idle(6);
    rd(0, 9'h120, v); check("R5 output pins ignored", v, 32'h0);
    pin_in_a = 32'hBEEE_0000;
    idle(6);
    rd(0, 9'h120, v); check("R5 falling", v, 32'h1);
    wr(0, 9'h120, 32'h1);
    rd(0, 9'h120, v); check("R5 clear", v, 32'h0);
    pin_in_a = 32'hBEEF_0000;
    idle(6);
    rd(0, 9'h120, v); check("R5 rising", v, 32'h1);

    // R6 write-one-to-clear
    wr(0, 9'h120, 32'h0);
    rd(0, 9'h120, v); check("R6 zero write", v, 32'h1);
    wr(0, 9'h120, 32'h2);
    rd(0, 9'h120, v); check("R6 other bit", v, 32'h1);
    wr(0, 9'h120, 32'h1);
    rd(0, 9'h120, v); check("R6 clear", v, 32'h0);

    // R7 interrupt gating
    pin_in_b = 32'h0000_0008;
    idle(6);
    rd(0, 9'h120, v); check("R7 bank b status", v, 32'h2);
    check("R7 idle irq", {31'h0, irq_m}, 32'h0);
    wr(0, 9'h128, 32'h2);
    idle(2);
    check("R7 global off", {31'h0, irq_m}, 32'h0);
    wr(0, 9'h11C, 32'h8000_0000);
    idle(2);
    check("R7 raised", {31'h0, irq_m}, 32'h1);
    wr(0, 9'h128, 32'h1);
    idle(2);
    check("R7 masked", {31'h0, irq_m}, 32'h0);
    wr(0, 9'h128, 32'h2);
    idle(2);
    check("R7 unmasked", {31'h0, irq_m}, 32'h1);
    wr(0, 9'h120, 32'h2);
    idle(2);
    check("R7 cleared", {31'h0, irq_m}, 32'h0);

    // R8 single-bank build, 8-bit bank A
    rd(1, 9'h000, v); check("R4 narrow reset", v, 32'h0);
    s_in_a = 8'hA5;
    idle(6);
    rd(1, 9'h000, v); check("R4 narrow upper zero", v, 32'h0000_00A5);
    wr(1, 9'h00C, 32'hFFFF_0000);
    rd(1, 9'h00C, v); check("R8 dir b", v, 32'h0);
    rd(1, 9'h008, v); check("R8 data b", v, 32'h0);
    check("R8 oe b", s_oe_b, 32'h0);
    wr(1, 9'h120, 32'h3);
    s_in_b = 32'hFFFF_FFFF;
    idle(6);
    rd(1, 9'h120, v); check("R8 no bank b status", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule